// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the single reservation that one processor holds for atomic read-modify-write sequences. A load-reserve request records the granule that holds the target address. A later store-conditional request succeeds only when that reservation is still live and covers the same granule. On success the block tells the store path to perform the write. Each store-conditional drops the reservation, whether it succeeds or fails.

A snoop port carries stores from other processors and other agents. A snoop store that lands anywhere in the reserved granule drops the reservation. Two kinds of request raise an error flag and do not touch the reservation: a request that is not aligned to its own size, and a request marked write-through or caching-inhibited. The granule size is a parameter. A second parameter selects whether the attribute check is enforced. Enforcement is the default, and it is mandatory for server-class systems.

Each request gets a registered response one cycle after it is presented. The live reservation flag is also driven to a port.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after a reset edge, `resv_valid` and `rsp_valid` are 0. This holds even if a reservation was live before the reset.
- R2: An aligned load-reserve without attribute flags sets `resv_valid` to 1 in the cycle after the request. In that cycle `rsp_valid` is 1 and both error flags are 0. Request code `req_op` = 2'b01 is load-reserve, 2'b10 is store-conditional, and 2'b00 and 2'b11 are idle.
- R3: A new load-reserve replaces any existing reservation. A later store-conditional to the old granule therefore fails.
- R4: A store-conditional reports `rsp_sc_ok`=1 in the cycle after the request only when all of these hold: the reservation is live, the request falls in the reserved granule, and no error is raised. `rsp_sc_ok` is also the store-perform strobe.
- R5: Every store-conditional leaves `resv_valid` at 0 in the following cycle, whatever its outcome.
- R6: A snoop store whose address lies in the reserved granule clears the reservation. A snoop store to any other granule leaves it intact. This rule does not apply in a cycle where a load-reserve is accepted (see R10).
- R7: When a store-conditional and a snoop store to the reserved granule arrive in the same cycle, the store-conditional fails.
- R8: A request whose address is not a multiple of 2^`req_size` bytes raises `rsp_align_err`. A misaligned load-reserve leaves the reservation unchanged. A misaligned store-conditional fails.
- R9: With `TRAP_ATTR`=1, a request with `req_wt` or `req_ci` set raises `rsp_attr_err`. A load-reserve with either flag leaves the reservation unchanged. A store-conditional with either flag fails.
- R10: An accepted load-reserve sets the reservation even if a snoop store to that same granule arrives in the same cycle.
- R11: Two addresses match when they differ only in the low `GRAN_LG2` bits, which is 64-byte granules by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | Request code: 01 load-reserve, 10 store-conditional, 00/11 idle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wt | input | 1 | Request targets write-through storage |
| req_ci | input | 1 | Request targets caching-inhibited storage |
| snoop_valid | input | 1 | A store by another agent is observed |
| snoop_addr | input | ADDR_W | Byte address of the observed store |
| rsp_valid | output | 1 | A response for last cycle's request is present |
| rsp_sc_ok | output | 1 | Store-conditional succeeded; perform the store |
| rsp_align_err | output | 1 | Last request was misaligned |
| rsp_attr_err | output | 1 | Last request had a forbidden storage attribute |
| resv_valid | output | 1 | A reservation is currently held |

## Verification
The block's whole state is one valid bit and one granule tag, so a wrong state shows up at the latest on the next store-conditional. A stale valid bit produces a spurious `rsp_sc_ok`. A wrongly dropped bit produces a missing one. A tag that was not replaced shows when a store-conditional aimed at the old granule succeeds. Losses caused by snoops and errors are visible on `resv_valid` one cycle after the event, and the bench checks `resv_valid` after every step rather than waiting for a store-conditional.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int SIZE_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LR   = 2'b01,
        OP_SC   = 2'b10,
        OP_RSVD = 2'b11
    } rsv_op_e;

    typedef struct packed {
        logic is_lr;
        logic is_sc;
        logic align_err;
        logic attr_err;
        logic clean;
    } req_chk_t;

    typedef struct packed {
        logic valid;
        logic sc_ok;
        logic align_err;
        logic attr_err;
    } rsp_t;

    // Low address byte must be a multiple of the access size.
    function automatic logic low_aligned(input logic [7:0] lo, input logic [SIZE_W-1:0] sz);
        logic [7:0] mask;
        mask = (8'd1 << sz) - 8'd1;
        return (lo & mask) == 8'd0;
    endfunction

endpackage

// File: rtl/rsv_req_check.sv
module rsv_req_check
    import rsv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter bit TRAP_ATTR = 1'b1
) (
    input  logic [1:0]        op,
    input  logic [7:0]        addr_lo,
    input  logic [SIZE_W-1:0] size,
    input  logic              wt,
    input  logic              ci,
    output req_chk_t          chk
);
    logic attr_bad;

    generate
        if (TRAP_ATTR) begin : g_trap
            assign attr_bad = wt | ci;
        end else begin : g_notrap
            logic unused_attr;
            assign unused_attr = wt ^ ci;
            assign attr_bad    = 1'b0;
        end
    endgenerate

    always_comb begin
        chk.is_lr     = (op == OP_LR);
        chk.is_sc     = (op == OP_SC);
        chk.align_err = (chk.is_lr | chk.is_sc) & ~low_aligned(addr_lo, size);
        chk.attr_err  = (chk.is_lr | chk.is_sc) & attr_bad;
        chk.clean     = ~chk.align_err & ~chk.attr_err;
    end
endmodule

// File: rtl/rsv_store.sv
module rsv_store #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 6,
    localparam int GRAN_W  = ADDR_W - GRAN_LG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              drop,
    input  logic [GRAN_W-1:0] req_gran,
    input  logic              snp_valid,
    input  logic [GRAN_W-1:0] snp_gran,
    output logic              valid,
    output logic [GRAN_W-1:0] gran,
    output logic              req_hit,
    output logic              snp_hit
);
    assign req_hit = valid & (req_gran == gran);
    assign snp_hit = valid & snp_valid & (snp_gran == gran);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            gran  <= '0;
        end else if (set) begin
            valid <= 1'b1;
            gran  <= req_gran;
        end else if (drop || snp_hit) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LG2  = 6,
    parameter bit TRAP_ATTR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_wt,
    input  logic              req_ci,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              rsp_valid,
    output logic              rsp_sc_ok,
    output logic              rsp_align_err,
    output logic              rsp_attr_err,
    output logic              resv_valid
);
    localparam int GRAN_W = ADDR_W - GRAN_LG2;

    req_chk_t          chk;
    rsp_t              rsp_d, rsp_q;
    logic              hit, snp_hit;
    logic [GRAN_W-1:0] resv_gran;
    logic              unused_lo;

    assign unused_lo = ^{req_addr[GRAN_LG2-1:0], snoop_addr[GRAN_LG2-1:0]};

    rsv_req_check #(.ADDR_W(ADDR_W), .TRAP_ATTR(TRAP_ATTR)) u_check (
        .op     (req_op),
        .addr_lo(req_addr[7:0]),
        .size   (req_size),
        .wt     (req_wt),
        .ci     (req_ci),
        .chk    (chk)
    );

    rsv_store #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_store (
        .clk      (clk),
        .rst      (rst),
        .set      (chk.is_lr & chk.clean),
        .drop     (chk.is_sc),
        .req_gran (req_addr[ADDR_W-1:GRAN_LG2]),
        .snp_valid(snoop_valid),
        .snp_gran (snoop_addr[ADDR_W-1:GRAN_LG2]),
        .valid    (resv_valid),
        .gran     (resv_gran),
        .req_hit  (hit),
        .snp_hit  (snp_hit)
    );

    always_comb begin
        rsp_d.valid     = chk.is_lr | chk.is_sc;
        rsp_d.sc_ok     = chk.is_sc & chk.clean & hit & ~snp_hit;
        rsp_d.align_err = chk.align_err;
        rsp_d.attr_err  = chk.attr_err;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_sc_ok     = rsp_q.sc_ok;
    assign rsp_align_err = rsp_q.align_err;
    assign rsp_attr_err  = rsp_q.attr_err;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 6,
    localparam int GRAN_W  = ADDR_W - GRAN_LG2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        req_op,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              rsp_valid,
    input logic              rsp_sc_ok,
    input logic              rsp_align_err,
    input logic              rsp_attr_err,
    input logic              resv_valid,
    input logic [GRAN_W-1:0] resv_gran
);
    logic is_lr, is_sc, snp_in_gran;
    assign is_lr       = (req_op == 2'b01);
    assign is_sc       = (req_op == 2'b10);
    assign snp_in_gran = snoop_valid & resv_valid & (snoop_addr[ADDR_W-1:GRAN_LG2] == resv_gran);

    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (!resv_valid && !rsp_valid));

    p_lr_sets_r2: assert property (@(posedge clk) disable iff (rst)
        is_lr |=> (resv_valid || rsp_align_err || rsp_attr_err));

    p_sc_needs_resv_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_sc_ok |-> $past(resv_valid));

    p_sc_clears_r5: assert property (@(posedge clk) disable iff (rst)
        is_sc |=> !resv_valid);

    p_snoop_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (snp_in_gran && !is_lr) |=> !resv_valid);

    p_err_blocks_sc_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_align_err || rsp_attr_err) |-> !rsp_sc_ok);

    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!is_lr && !is_sc && !snoop_valid) |=> $stable(resv_valid));
endmodule

bind rsv_monitor rsv_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_op       (req_op),
    .snoop_valid  (snoop_valid),
    .snoop_addr   (snoop_addr),
    .rsp_valid    (rsp_valid),
    .rsp_sc_ok    (rsp_sc_ok),
    .rsp_align_err(rsp_align_err),
    .rsp_attr_err (rsp_attr_err),
    .resv_valid   (resv_valid),
    .resv_gran    (resv_gran)
);

// File: tb/rsv_monitor_bench.sv
module rsv_monitor_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_op;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_wt, req_ci, snoop_valid;
    logic [31:0] snoop_addr;
    logic        rsp_valid, rsp_sc_ok, rsp_align_err, rsp_attr_err, resv_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rsv_monitor u_rsv_monitor (
        .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
        .req_wt(req_wt), .req_ci(req_ci), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .rsp_valid(rsp_valid), .rsp_sc_ok(rsp_sc_ok), .rsp_align_err(rsp_align_err),
        .rsp_attr_err(rsp_attr_err), .resv_valid(resv_valid)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wt;
        logic        ci;
        logic        snv;
        logic [31:0] sna;
        logic [4:0]  exp;  // rsp_valid, sc_ok, align_err, attr_err, resv_valid
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 32'h100, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},  // R2
        '{2'b10, 32'h13C, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b11000, 4'd11}, // R11 R4
        '{2'b10, 32'h100, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10000, 4'd5},  // R5
        '{2'b01, 32'h200, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b01, 32'h300, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd3},  // R3
        '{2'b10, 32'h200, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10000, 4'd3},  // R3
        '{2'b01, 32'h400, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b00, 32'h0,   2'd0, 1'b0, 1'b0, 1'b1, 32'h480, 5'b00001, 4'd6},  // R6 miss
        '{2'b00, 32'h0,   2'd0, 1'b0, 1'b0, 1'b1, 32'h43F, 5'b00000, 4'd6},  // R6 hit
        '{2'b10, 32'h400, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10000, 4'd6},
        '{2'b01, 32'h500, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b10, 32'h500, 2'd2, 1'b0, 1'b0, 1'b1, 32'h520, 5'b10000, 4'd7},  // R7
        '{2'b01, 32'h600, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b10, 32'h600, 2'd2, 1'b0, 1'b0, 1'b1, 32'h700, 5'b11000, 4'd7},  // R7 other granule
        '{2'b01, 32'h702, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10100, 4'd8},  // R8
        '{2'b01, 32'h800, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b01, 32'h901, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10101, 4'd8},  // R8 keeps
        '{2'b10, 32'h800, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b11000, 4'd8},
        '{2'b01, 32'hA00, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0,   5'b10010, 4'd9},  // R9
        '{2'b01, 32'hA00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b01, 32'hB00, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0,   5'b10011, 4'd9},  // R9 keeps
        '{2'b10, 32'hA00, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0,   5'b10010, 4'd9},  // R9 sc fails
        '{2'b01, 32'hC00, 2'd2, 1'b0, 1'b0, 1'b1, 32'hC10, 5'b10001, 4'd10}, // R10
        '{2'b10, 32'hC04, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b11000, 4'd10},
        '{2'b10, 32'hD03, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10100, 4'd8},  // R8 sc
        '{2'b01, 32'hE01, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,   5'b10001, 4'd2},
        '{2'b10, 32'hE3F, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,   5'b11000, 4'd11}  // R11
    };

    function automatic logic [4:0] outs();
        return {rsp_valid, rsp_sc_ok, rsp_align_err, rsp_attr_err, resv_valid};
    endfunction

    task automatic check(input logic [4:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, outs(), exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [1:0] sz,
                        input logic wt, input logic ci, input logic snv, input logic [31:0] sna);
        req_op = op; req_addr = a; req_size = sz; req_wt = wt; req_ci = ci;
        snoop_valid = snv; snoop_addr = sna;
        @(posedge clk);
        @(negedge clk);
        req_op = 2'b00; snoop_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_op = 2'b00; req_addr = '0; req_size = '0;
        req_wt = 1'b0; req_ci = 1'b0; snoop_valid = 1'b0; snoop_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(5'b00000, "R1 reset state");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].op, VECS[i].addr, VECS[i].size, VECS[i].wt, VECS[i].ci,
                 VECS[i].snv, VECS[i].sna);
            check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R2: reserved op code 11 is idle and leaves the reservation untouched
        step(2'b01, 32'hF00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0);
        check(5'b10001, "R2 lr before idle code");
        step(2'b11, 32'hF00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0);
        check(5'b00001, "R2 op 11 idle");

        // R1: reset in the middle drops a live reservation
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(5'b00000, "R1 mid-run reset");
        step(2'b10, 32'hF00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0);
        check(5'b10000, "R1 sc after reset fails");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule